// File: doc/BRIEF.md
# Multidrop Test-Bus Slot Selector

This block decides whether the local device takes part in scan traffic on a test bus shared by many boards. It sits next to the board's own TAP controller and watches for an Update-IR event. While the device is not selected, the value just shifted into the instruction register is treated as an address. It is compared against the board's 8-bit slot identification pins, against a broadcast code, against an interrogation code and against four multicast group codes. A matching unique address selects the device and lets it drive TDO. Broadcast and multicast select the device but keep TDO off, so two boards never fight over the shared return line. Interrogation selects nobody. For one shift pass it makes every device drive its slot number onto TDO, so that the bus master can learn which slots are occupied.

Once the device is selected, later instruction loads pass through as ordinary instructions. The exceptions are a deselect code and, while the device is uniquely selected, two codes that write or clear the multicast group register. An address-mask pin narrows the unique comparison to the upper slot bits, so that one address can reach a bank of neighbouring slots. The synchronous reset and the active-low test reset both return the block to its idle state.

Top module: `mdrop_slot_sel`

## Requirements
- R1: While `rst` is high or `trst_n` is low at a clock edge, the block returns to idle after that edge: `selected`, `interrog_active` and `tdo_en` are 0, and the group register is emptied, so no multicast code matches afterwards.
- R2: An Update-IR (`upd_ir` high for one cycle) while unselected, with `ir_value` in 0x01..0xF9 and equal to `slot_id`, sets `selected` and `tdo_en` to 1 on the next cycle. A value that differs leaves the device unselected.
- R3: An `ir_value` of 0x00 never selects the device, whatever the values of `slot_id` and `addr_mask`.
- R4: With `addr_mask` high, the unique comparison checks only bits 7:4 of `ir_value` against `slot_id`. Bits 3:0 are ignored. With `addr_mask` low, all 8 bits must match.
- R5: Code 0xFB (broadcast) selects an unselected device regardless of `slot_id`, with `tdo_en` held at 0.
- R6: Code 0xFA (interrogation) leaves `selected` at 0 and raises `interrog_active`. While it is active, `tdo_en` equals `shift_dr`. `interrog_tdo` presents `slot_id` LSB first, advancing one bit per cycle with `shift_dr` high, and presents 1 once the eight bits are used up. `upd_dr` or the next `upd_ir` ends it.
- R7: Code 0xFC+g (g = 0..3) selects an unselected device only when its group register holds group g. `tdo_en` stays 0 while the device is selected this way.
- R8: While uniquely selected, Update-IR with 0xF4+g loads group g and Update-IR with 0xF8 empties the group register. These codes have no effect on a device that is selected by broadcast or multicast.
- R9: While selected, Update-IR with 0xF0 deselects. Any other value, including slot, broadcast, interrogation and reserved codes, leaves the selection and `tdo_en` unchanged and does not start an interrogation.
- R10: When reset and an address-matching Update-IR occur in the same cycle, reset wins and the device stays unselected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst | input | 1 | Synchronous active-high reset |
| trst_n | input | 1 | Active-low test reset, sampled on `clk` |
| slot_id | input | 8 | Board slot identification |
| addr_mask | input | 1 | Ignore slot bits 3:0 in the unique comparison |
| ir_value | input | 8 | Instruction register contents at Update-IR |
| upd_ir | input | 1 | One-cycle Update-IR strobe from the TAP controller |
| upd_dr | input | 1 | One-cycle Update-DR strobe from the TAP controller |
| shift_dr | input | 1 | High in each Shift-DR cycle |
| selected | output | 1 | Device is selected (unique, broadcast or multicast) |
| interrog_active | output | 1 | Interrogation pass in progress |
| tdo_en | output | 1 | Permission to drive the shared TDO line |
| interrog_tdo | output | 1 | Serial slot number during interrogation, else 0 |

## Verification
Two events can arrive in the same cycle: a test reset and an Update-IR that carries this board's own address. The bench drives `trst_n` low, or `rst` high, on the very edge that presents a matching or broadcast code. It then requires `selected` to read 0 on the following cycle. A selection written before the reset must also not survive it: a multicast code that matched before the reset must fail to match after it. In the same way, an Update-IR that arrives during an interrogation pass must end that pass without selecting the device.

// File: rtl/mdsel_pkg.sv
package mdsel_pkg;

    localparam int ADDR_W_DEF  = 8;
    localparam int N_GRP_DEF   = 4;
    localparam int MASK_LO_DEF = 4;

    typedef enum logic [1:0] {
        SEL_NONE   = 2'd0,
        SEL_UNIQUE = 2'd1,
        SEL_BCAST  = 2'd2,
        SEL_GROUP  = 2'd3
    } sel_kind_e;

    // Address-phase decode of the loaded instruction value
    typedef struct packed {
        logic uniq;
        logic bcast;
        logic interrog;
        logic group;
    } addr_hit_t;

    // Selected-phase control codes
    typedef struct packed {
        logic desel;
        logic gset;
        logic gclr;
    } cmd_hit_t;

    // Only a unique selection may own the shared return line
    function automatic logic owns_tdo(sel_kind_e k);
        return k == SEL_UNIQUE;
    endfunction

endpackage

// File: rtl/mdsel_addr_cmp.sv
module mdsel_addr_cmp
    import mdsel_pkg::*;
#(
    parameter  int ADDR_W  = ADDR_W_DEF,
    parameter  int N_GRP   = N_GRP_DEF,
    parameter  int MASK_LO = MASK_LO_DEF,
    localparam int GRP_W   = (N_GRP > 1) ? $clog2(N_GRP) : 1
) (
    input  logic [ADDR_W-1:0] ir_value,
    input  logic [ADDR_W-1:0] slot_id,
    input  logic              addr_mask,
    input  logic              grp_valid,
    input  logic [GRP_W-1:0]  grp_num,
    output addr_hit_t         hit
);

    localparam int unsigned SPACE   = 2 ** ADDR_W;
    localparam int unsigned MC_BASE = SPACE - N_GRP;
    localparam int unsigned BC_CODE = MC_BASE - 1;
    localparam int unsigned IQ_CODE = MC_BASE - 2;
    localparam int unsigned UQ_MAX  = MC_BASE - 3;

    logic [ADDR_W-1:0] bit_eq;
    logic [N_GRP-1:0]  mc_hit;

    // Per-bit slot comparison; the low bits may be masked off
    for (genvar i = 0; i < ADDR_W; i++) begin : g_bit
        if (i < MASK_LO) begin : g_maskable
            assign bit_eq[i] = addr_mask | (ir_value[i] == slot_id[i]);
        end else begin : g_fixed
            assign bit_eq[i] = (ir_value[i] == slot_id[i]);
        end
    end

    // One comparator per multicast group
    for (genvar g = 0; g < N_GRP; g++) begin : g_grp
        assign mc_hit[g] = grp_valid
                         && (grp_num == GRP_W'(g))
                         && (ir_value == ADDR_W'(MC_BASE + g));
    end

    always_comb begin
        hit.interrog = (ir_value == ADDR_W'(IQ_CODE));
        hit.bcast    = (ir_value == ADDR_W'(BC_CODE));
        hit.group    = |mc_hit;
        hit.uniq     = (ir_value != '0)
                     && (32'(ir_value) <= UQ_MAX)
                     && (&bit_eq);
    end

    // R2: a unique hit never coincides with a reserved or shared code
    always_comb begin
        if (hit.uniq) begin
            p_uniq_excl_r2: assert (!(hit.bcast || hit.interrog || hit.group))
                else $error("unique hit overlaps a shared code");
        end
    end

endmodule

// File: rtl/mdsel_cmd_dec.sv
module mdsel_cmd_dec
    import mdsel_pkg::*;
#(
    parameter  int ADDR_W = ADDR_W_DEF,
    parameter  int N_GRP  = N_GRP_DEF,
    localparam int GRP_W  = (N_GRP > 1) ? $clog2(N_GRP) : 1
) (
    input  logic [ADDR_W-1:0] ir_value,
    output cmd_hit_t          cmd,
    output logic [GRP_W-1:0]  cmd_grp
);

    localparam int unsigned SPACE     = 2 ** ADDR_W;
    localparam int unsigned DESEL_C   = SPACE - 4 * N_GRP;
    localparam int unsigned GSET_BASE = SPACE - 3 * N_GRP;
    localparam int unsigned GCLR_C    = SPACE - 2 * N_GRP;

    logic [ADDR_W-1:0] gset_off;

    assign gset_off = ir_value - ADDR_W'(GSET_BASE);

    always_comb begin
        cmd.desel = (ir_value == ADDR_W'(DESEL_C));
        cmd.gclr  = (ir_value == ADDR_W'(GCLR_C));
        cmd.gset  = (32'(ir_value) >= GSET_BASE)
                 && (32'(ir_value) < GSET_BASE + N_GRP);
        cmd_grp   = gset_off[GRP_W-1:0];
    end

endmodule

// File: rtl/mdsel_sel_state.sv
module mdsel_sel_state
    import mdsel_pkg::*;
#(
    parameter int GRP_W = 2
) (
    input  logic             clk,
    input  logic             clr,
    input  logic             upd_ir,
    input  addr_hit_t        hit,
    input  cmd_hit_t         cmd,
    input  logic [GRP_W-1:0] cmd_grp,
    output sel_kind_e        kind,
    output logic             grp_valid,
    output logic [GRP_W-1:0] grp_num
);

    always_ff @(posedge clk) begin
        if (clr) begin
            kind      <= SEL_NONE;
            grp_valid <= 1'b0;
            grp_num   <= '0;
        end else if (upd_ir) begin
            if (kind == SEL_NONE) begin
                // Address phase: interrogation falls through and selects nothing
                if (hit.bcast)      kind <= SEL_BCAST;
                else if (hit.group) kind <= SEL_GROUP;
                else if (hit.uniq)  kind <= SEL_UNIQUE;
            end else if (cmd.desel) begin
                kind <= SEL_NONE;
            end else if (kind == SEL_UNIQUE) begin
                if (cmd.gset) begin
                    grp_valid <= 1'b1;
                    grp_num   <= cmd_grp;
                end else if (cmd.gclr) begin
                    grp_valid <= 1'b0;
                    grp_num   <= '0;
                end
            end
        end
    end

    // R1: leaving reset always finds the block idle with no group
    p_reset_idle_r1: assert property (@(posedge clk) disable iff (clr)
        $fell(clr) |-> (kind == SEL_NONE) && !grp_valid);

    // R9: an ordinary instruction keeps the current selection
    p_sticky_r9: assert property (@(posedge clk) disable iff (clr)
        (kind != SEL_NONE) && upd_ir && !cmd.desel |=> kind == $past(kind));

    // R9: the deselect code always releases the device
    p_desel_r9: assert property (@(posedge clk) disable iff (clr)
        (kind != SEL_NONE) && upd_ir && cmd.desel |=> kind == SEL_NONE);

    // R8: the group register moves only under a unique selection
    p_grp_guard_r8: assert property (@(posedge clk) disable iff (clr)
        (kind != SEL_UNIQUE) |=> $stable(grp_valid) && $stable(grp_num));

    // R9: without an Update-IR nothing changes
    p_idle_hold_r9: assert property (@(posedge clk) disable iff (clr)
        !upd_ir |=> $stable(kind));

endmodule

// File: rtl/mdsel_interrog.sv
module mdsel_interrog
    import mdsel_pkg::*;
#(
    parameter int ADDR_W = ADDR_W_DEF
) (
    input  logic              clk,
    input  logic              clr,
    input  logic              upd_ir,
    input  logic              start,
    input  logic              upd_dr,
    input  logic              shift_dr,
    input  logic [ADDR_W-1:0] slot_id,
    output logic              active,
    output logic              tdo_bit
);

    logic [ADDR_W-1:0] sreg;

    always_ff @(posedge clk) begin
        if (clr) begin
            active <= 1'b0;
            sreg   <= '1;
        end else if (upd_ir) begin
            active <= start;
            if (start) sreg <= slot_id;
        end else if (upd_dr) begin
            active <= 1'b0;
        end else if (active && shift_dr) begin
            sreg <= {1'b1, sreg[ADDR_W-1:1]};
        end
    end

    assign tdo_bit = active & sreg[0];

    // R6: an interrogation code arms the pass on the next cycle
    p_arm_r6: assert property (@(posedge clk) disable iff (clr)
        upd_ir && start |=> active);

    // R6: the pass lasts one data-register scan only
    p_one_pass_r6: assert property (@(posedge clk) disable iff (clr)
        active && upd_dr && !upd_ir |=> !active);

    // R6: the pattern stays put when no shift occurs
    p_hold_pat_r6: assert property (@(posedge clk) disable iff (clr)
        active && !shift_dr && !upd_ir && !upd_dr |=> $stable(tdo_bit));

endmodule

// File: rtl/mdrop_slot_sel.sv
module mdrop_slot_sel
    import mdsel_pkg::*;
#(
    parameter int ADDR_W  = ADDR_W_DEF,
    parameter int N_GRP   = N_GRP_DEF,
    parameter int MASK_LO = MASK_LO_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              trst_n,
    input  logic [ADDR_W-1:0] slot_id,
    input  logic              addr_mask,
    input  logic [ADDR_W-1:0] ir_value,
    input  logic              upd_ir,
    input  logic              upd_dr,
    input  logic              shift_dr,
    output logic              selected,
    output logic              interrog_active,
    output logic              tdo_en,
    output logic              interrog_tdo
);

    localparam int          GRP_W   = (N_GRP > 1) ? $clog2(N_GRP) : 1;
    localparam int unsigned SPACE   = 2 ** ADDR_W;
    localparam int unsigned BC_CODE = SPACE - N_GRP - 1;
    localparam int unsigned UQ_MAX  = SPACE - N_GRP - 3;

    logic             clr;
    addr_hit_t        hit;
    cmd_hit_t         cmd;
    logic [GRP_W-1:0] cmd_grp;
    sel_kind_e        kind;
    logic             grp_valid;
    logic [GRP_W-1:0] grp_num;
    logic             iq_start;
    logic             iq_bit;

    assign clr = rst | ~trst_n;

    mdsel_addr_cmp #(
        .ADDR_W (ADDR_W),
        .N_GRP  (N_GRP),
        .MASK_LO(MASK_LO)
    ) u_cmp (
        .ir_value (ir_value),
        .slot_id  (slot_id),
        .addr_mask(addr_mask),
        .grp_valid(grp_valid),
        .grp_num  (grp_num),
        .hit      (hit)
    );

    mdsel_cmd_dec #(
        .ADDR_W(ADDR_W),
        .N_GRP (N_GRP)
    ) u_cmd (
        .ir_value(ir_value),
        .cmd     (cmd),
        .cmd_grp (cmd_grp)
    );

    mdsel_sel_state #(
        .GRP_W(GRP_W)
    ) u_state (
        .clk      (clk),
        .clr      (clr),
        .upd_ir   (upd_ir),
        .hit      (hit),
        .cmd      (cmd),
        .cmd_grp  (cmd_grp),
        .kind     (kind),
        .grp_valid(grp_valid),
        .grp_num  (grp_num)
    );

    assign iq_start = (kind == SEL_NONE) & hit.interrog;

    mdsel_interrog #(
        .ADDR_W(ADDR_W)
    ) u_iq (
        .clk     (clk),
        .clr     (clr),
        .upd_ir  (upd_ir),
        .start   (iq_start),
        .upd_dr  (upd_dr),
        .shift_dr(shift_dr),
        .slot_id (slot_id),
        .active  (interrog_active),
        .tdo_bit (iq_bit)
    );

    assign selected     = (kind != SEL_NONE);
    assign tdo_en       = owns_tdo(kind) | (interrog_active & shift_dr);
    assign interrog_tdo = iq_bit;

    // R3: the all-zero code never selects
    p_reserved_r3: assert property (@(posedge clk) disable iff (clr)
        upd_ir && !selected && (ir_value == '0) |=> !selected);

    // R2: an exact slot match selects and enables TDO
    p_unique_r2: assert property (@(posedge clk) disable iff (clr)
        upd_ir && !selected && (ir_value == slot_id) && (ir_value != '0)
        && (32'(ir_value) <= UQ_MAX) |=> selected && tdo_en);

    // R5: broadcast selects but keeps the shared line quiet
    p_bcast_quiet_r5: assert property (@(posedge clk) disable iff (clr)
        upd_ir && !selected && (ir_value == ADDR_W'(BC_CODE))
        |=> selected && !tdo_en);

    // R6: an interrogation pass never coexists with a selection
    p_iq_unsel_r6: assert property (@(posedge clk) disable iff (clr)
        interrog_active |-> !selected);

    // R10: a test reset beats a same-cycle address match
    p_trst_wins_r10: assert property (@(posedge clk) disable iff (rst)
        !trst_n |=> !selected && !interrog_active);

endmodule

// File: tb/test_mdrop_slot_sel.sv
module test_mdrop_slot_sel;

    logic       clk = 1'b0;
    logic       rst;
    logic       trst_n;
    logic [7:0] slot_id;
    logic       addr_mask;
    logic [7:0] ir_value;
    logic       upd_ir;
    logic       upd_dr;
    logic       shift_dr;
    logic       selected;
    logic       interrog_active;
    logic       tdo_en;
    logic       interrog_tdo;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    mdrop_slot_sel i_mdrop_slot_sel (
        .clk            (clk),
        .rst            (rst),
        .trst_n         (trst_n),
        .slot_id        (slot_id),
        .addr_mask      (addr_mask),
        .ir_value       (ir_value),
        .upd_ir         (upd_ir),
        .upd_dr         (upd_dr),
        .shift_dr       (shift_dr),
        .selected       (selected),
        .interrog_active(interrog_active),
        .tdo_en         (tdo_en),
        .interrog_tdo   (interrog_tdo)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    // Update-IR with the given code; returns just after the next negedge
    task automatic load_ir(input logic [7:0] code);
        @(negedge clk);
        ir_value = code;
        upd_ir   = 1'b1;
        @(negedge clk);
        upd_ir   = 1'b0;
        #1;
    endtask

    task automatic pulse_dr();
        @(negedge clk);
        upd_dr = 1'b1;
        @(negedge clk);
        upd_dr = 1'b0;
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 selected after reset", selected, 0);
        chk("R1 interrog after reset", interrog_active, 0);
        chk("R1 tdo_en after reset", tdo_en, 0);
    endtask

    task automatic t_unique();
        slot_id = 8'h5A; addr_mask = 1'b0;
        load_ir(8'h5B);
        chk("R2 mismatch stays off", selected, 0);
        load_ir(8'h5A);
        chk("R2 match selects", selected, 1);
        chk("R2 match enables tdo", tdo_en, 1);
        load_ir(8'hF0);
        chk("R9 deselect code", selected, 0);
        chk("R9 tdo off after deselect", tdo_en, 0);
    endtask

    task automatic t_reserved();
        slot_id = 8'h00; addr_mask = 1'b0;
        load_ir(8'h00);
        chk("R3 zero with zero slot", selected, 0);
        slot_id = 8'h03; addr_mask = 1'b1;
        load_ir(8'h00);
        chk("R3 zero under mask", selected, 0);
        addr_mask = 1'b0;
    endtask

    task automatic t_mask();
        slot_id = 8'h37; addr_mask = 1'b1;
        load_ir(8'h3C);
        chk("R4 masked low nibble matches", selected, 1);
        chk("R4 masked match owns tdo", tdo_en, 1);
        load_ir(8'hF0);
        addr_mask = 1'b0;
        load_ir(8'h3C);
        chk("R4 unmasked low nibble differs", selected, 0);
        addr_mask = 1'b1;
        load_ir(8'h47);
        chk("R4 masked high nibble differs", selected, 0);
        addr_mask = 1'b0;
    endtask

    task automatic t_bcast();
        slot_id = 8'h21;
        load_ir(8'hFB);
        chk("R5 broadcast selects", selected, 1);
        chk("R5 broadcast tdo quiet", tdo_en, 0);
        load_ir(8'hF0);
        chk("R5 broadcast released", selected, 0);
    endtask

    task automatic t_interrog();
        logic [7:0] pat;
        pat = 8'hA5;
        slot_id = pat;
        load_ir(8'hFA);
        chk("R6 interrogation no select", selected, 0);
        chk("R6 interrogation active", interrog_active, 1);
        chk("R6 tdo off outside shift", tdo_en, 0);
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            shift_dr = 1'b1;
            #1;
            chk("R6 tdo on in shift", tdo_en, 1);
            chk("R6 pattern bit", interrog_tdo, (k < 8) ? int'(pat[k]) : 1);
        end
        @(negedge clk);
        shift_dr = 1'b0;
        #1;
        chk("R6 tdo off after shift", tdo_en, 0);
        chk("R6 still active before update", interrog_active, 1);
        pulse_dr();
        chk("R6 update-dr ends pass", interrog_active, 0);
        chk("R6 pattern idle", interrog_tdo, 0);
        load_ir(8'hFA);
        load_ir(8'h10);
        chk("R6 update-ir ends pass", interrog_active, 0);
        chk("R6 non-matching load no select", selected, 0);
    endtask

    task automatic t_group();
        slot_id = 8'h12;
        load_ir(8'hFD);
        chk("R7 empty group no match", selected, 0);
        load_ir(8'h12);
        load_ir(8'hF5);
        chk("R8 group write keeps unique", tdo_en, 1);
        load_ir(8'hF0);
        load_ir(8'hFD);
        chk("R7 own group selects", selected, 1);
        chk("R7 group tdo quiet", tdo_en, 0);
        load_ir(8'hF0);
        load_ir(8'hFE);
        chk("R7 other group no match", selected, 0);
        load_ir(8'hFB);
        load_ir(8'hF6);
        load_ir(8'hF0);
        load_ir(8'hFE);
        chk("R8 write under broadcast ignored", selected, 0);
        load_ir(8'hFD);
        chk("R8 old group kept", selected, 1);
        load_ir(8'hF0);
        load_ir(8'h12);
        load_ir(8'hF8);
        load_ir(8'hF0);
        load_ir(8'hFD);
        chk("R8 cleared group no match", selected, 0);
    endtask

    task automatic t_sticky();
        slot_id = 8'h12;
        load_ir(8'h12);
        load_ir(8'h44);
        chk("R9 ordinary load keeps select", selected, 1);
        load_ir(8'hFA);
        chk("R9 interrogation code ignored", interrog_active, 0);
        chk("R9 tdo kept", tdo_en, 1);
        load_ir(8'h00);
        chk("R9 zero code ignored", selected, 1);
        load_ir(8'hFB);
        chk("R9 broadcast code keeps unique tdo", tdo_en, 1);
        load_ir(8'hF0);
        chk("R9 release", selected, 0);
    endtask

    task automatic t_collide();
        slot_id = 8'h33;
        @(negedge clk);
        ir_value = 8'h33; upd_ir = 1'b1; trst_n = 1'b0;
        @(negedge clk);
        upd_ir = 1'b0; trst_n = 1'b1;
        #1;
        chk("R10 trst beats match", selected, 0);
        @(negedge clk);
        ir_value = 8'hFB; upd_ir = 1'b1; rst = 1'b1;
        @(negedge clk);
        upd_ir = 1'b0; rst = 1'b0;
        #1;
        chk("R10 rst beats broadcast", selected, 0);
        // R1: a test reset empties the group register
        load_ir(8'h33);
        load_ir(8'hF7);
        load_ir(8'hF0);
        load_ir(8'hFF);
        chk("R1 group set before trst", selected, 1);
        @(negedge clk);
        trst_n = 1'b0;
        @(negedge clk);
        trst_n = 1'b1;
        #1;
        chk("R1 trst deselects", selected, 0);
        load_ir(8'hFF);
        chk("R1 trst empties group", selected, 0);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; trst_n = 1'b1; slot_id = 8'h00; addr_mask = 1'b0;
        ir_value = 8'h00; upd_ir = 1'b0; upd_dr = 1'b0; shift_dr = 1'b0;
        t_reset();
        t_unique();
        t_reserved();
        t_mask();
        t_bcast();
        t_interrog();
        t_group();
        t_sticky();
        t_collide();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule